// File: doc/BRIEF.md
# SDRAM Bank Decoder and Row/Column Address Multiplexer

This block sits between a memory controller's access sequencer and a set of up to eight SDRAM banks. Each bank can have its own size. Firmware describes the banks through a small write port at boot. For each bank it sets an enable, a row-width code, and an inclusive start and end boundary counted in 1 MB units.

When an access request arrives, the block compares the megabyte index of the 32-bit physical address against every bank's range. One cycle later it drives exactly one active-low chip select. If no bank claims the address, it raises a single-cycle miss flag instead.

The address pins are multiplexed. A phase input selects whether the registered outputs carry the row mapping or the column mapping of the latched address. Address bits are numbered big-endian in the mapping rules: A0 is the most significant bit (`addr_i[31]`) and A31 the least significant (`addr_i[0]`). Memory address line SDMA0 is `ma_o[11]` and SDMA11 is `ma_o[0]`.

Top module: `sdram_bank_mux`

## Requirements
- R1: After reset all eight chip selects `cs_n_o` are high (8'hFF), `no_bank_o` is 0, and `ba_o` and `ma_o` are 0.
- R2: A cycle with `cfg_we_i` high stores enable, row-width code, start and end for bank `cfg_bank_i`. Requests from the following cycle onward use the new values.
- R3: A bank claims an access when its start ≤ `addr_i[31:20]` ≤ its end, with both bounds inclusive. Its chip select `cs_n_o[bank]` goes low in the cycle after `req_i`, and all other selects stay high.
- R4: Only row-width code 2'b11 (12 row bits) makes a bank eligible. Any other code makes the bank claim nothing.
- R5: An access claimed by no eligible bank leaves all selects high. It raises `no_bank_o` for exactly the one cycle after `req_i`.
- R6: When ranges of eligible banks overlap, the lowest-numbered bank wins, so at most one select is low.
- R7: Chip selects change only on a request cycle. They hold their value through the following row and column phases.
- R8: With `phase_i`=0 (row), `ba_o` = A9, SDMA1..SDMA11 = A10..A20, and SDMA0 = 0.
- R9: With `phase_i`=1 (column), `ba_o` = A5, SDMA1..3 = A6..8, SDMA4..11 = A21..28, and SDMA0 = 0. A29..A31 never reach the pins.
- R10: A bank written with its enable low claims nothing, even if its range covers the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Bank descriptor write strobe |
| cfg_bank_i | input | 3 | Bank index being written |
| cfg_en_i | input | 1 | Bank enable value |
| cfg_row_bits_i | input | 2 | Row-width code (2'b11 = 12 rows) |
| cfg_start_i | input | 12 | First megabyte of the bank, inclusive |
| cfg_end_i | input | 12 | Last megabyte of the bank, inclusive |
| req_i | input | 1 | New access, address valid |
| addr_i | input | 32 | Physical address |
| phase_i | input | 1 | 0 selects row mapping, 1 selects column mapping |
| cs_n_o | output | 8 | Active-low chip selects, one per bank |
| ba_o | output | 1 | Bank address line |
| ma_o | output | 12 | Memory address lines, ma_o[11] = SDMA0 |
| no_bank_o | output | 1 | One-cycle flag: access matched no bank |

## Verification
The bench places addresses exactly on the first and last megabyte of adjacent banks. An exclusive comparison there would either drop an edge address into the miss path or hand it to the neighbour. It builds overlapping ranges in which the higher-numbered bank also matches. A design with reversed priority, or with no priority, shows the wrong select or two low selects.

The bench also programs a bank with a wrong row-width code, and re-programs a bank to disabled. A decoder that ignored either field would still select those banks. Both mappings are checked against a model written in big-endian bit numbering, using addresses with alternating bit patterns. This exposes any off-by-one or reversed field in the row and column multiplexing. The select is also checked to stay fixed through the column phase.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;
  localparam int unsigned MB_W   = 12;
  localparam int unsigned MA_W   = 12;
  localparam logic [1:0]  ROWS_12 = 2'b11;

  typedef enum logic {PH_ROW = 1'b0, PH_COL = 1'b1} phase_e;

  typedef struct packed {
    logic            en;
    logic [1:0]      row_bits;
    logic [MB_W-1:0] first_mb;
    logic [MB_W-1:0] last_mb;
  } bank_desc_t;
endpackage

// File: rtl/bank_desc_regs.sv
module bank_desc_regs
  import sdram_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned SEL_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  bank_desc_t           desc_i,
  output bank_desc_t           desc_o [NUM_BANKS]
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                desc_o[b] <= '0;
      else if (we_i && sel_i == SEL_W'(b))        desc_o[b] <= desc_i;
    end
  end
endmodule

// File: rtl/bank_match.sv
module bank_match
  import sdram_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic [MB_W-1:0]      mb_i,
  input  bank_desc_t           desc_i [NUM_BANKS],
  output logic [NUM_BANKS-1:0] sel_o
);
  logic [NUM_BANKS-1:0] raw_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    assign raw_hit[b] = desc_i[b].en && (desc_i[b].row_bits == ROWS_12) &&
                        (mb_i >= desc_i[b].first_mb) && (mb_i <= desc_i[b].last_mb);
  end

  // lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    sel_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (raw_hit[b] && !taken) begin
        sel_o[b] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_mux.sv
module addr_mux
  import sdram_bank_pkg::*;
(
  input  logic [26:3]     a_i,
  input  logic            phase_i,
  output logic            ba_o,
  output logic [MA_W-1:0] ma_o
);
  // Little-endian slices; big-endian An equals addr[31-n].
  always_comb begin
    if (phase_e'(phase_i) == PH_COL) begin
      ba_o = a_i[26];
      ma_o = {1'b0, a_i[25:23], a_i[10:3]};
    end else begin
      ba_o = a_i[22];
      ma_o = {1'b0, a_i[21:11]};
    end
  end
endmodule

// File: rtl/sdram_bank_mux.sv
module sdram_bank_mux
  import sdram_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned SEL_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [SEL_W-1:0]     cfg_bank_i,
  input  logic                 cfg_en_i,
  input  logic [1:0]           cfg_row_bits_i,
  input  logic [MB_W-1:0]      cfg_start_i,
  input  logic [MB_W-1:0]      cfg_end_i,
  input  logic                 req_i,
  input  logic [31:0]          addr_i,
  input  logic                 phase_i,
  output logic [NUM_BANKS-1:0] cs_n_o,
  output logic                 ba_o,
  output logic [MA_W-1:0]      ma_o,
  output logic                 no_bank_o
);
  bank_desc_t           desc_q [NUM_BANKS];
  bank_desc_t           desc_wr;
  logic [NUM_BANKS-1:0] sel;
  logic [26:3]          addr_q, addr_cur;
  logic                 ba_d;
  logic [MA_W-1:0]      ma_d;
  logic                 unused_lsb;

  assign unused_lsb = ^addr_i[2:0];
  assign desc_wr    = '{en: cfg_en_i, row_bits: cfg_row_bits_i,
                        first_mb: cfg_start_i, last_mb: cfg_end_i};

  bank_desc_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .sel_i(cfg_bank_i),
    .desc_i(desc_wr), .desc_o(desc_q)
  );

  bank_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .mb_i(addr_i[31:20]), .desc_i(desc_q), .sel_o(sel)
  );

  assign addr_cur = req_i ? addr_i[26:3] : addr_q;

  addr_mux u_mux (.a_i(addr_cur), .phase_i, .ba_o(ba_d), .ma_o(ma_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_o    <= '1;
      no_bank_o <= 1'b0;
      addr_q    <= '0;
      ba_o      <= 1'b0;
      ma_o      <= '0;
    end else begin
      no_bank_o <= req_i && (sel == '0);
      if (req_i) begin
        cs_n_o <= ~sel;
        addr_q <= addr_i[26:3];
      end
      ba_o <= ba_d;
      ma_o <= ma_d;
    end
  end

  assert_cs_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  assert_miss_no_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_bank_o |-> (cs_n_o == '1));
  assert_miss_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_bank_o |=> !no_bank_o || $past(req_i));
  assert_cs_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(cs_n_o));
  assert_sdma0_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_i) |=> !ma_o[MA_W-1]);
endmodule

// File: tb/sim_sdram_bank_mux.sv
`timescale 1ns/1ps
module sim_sdram_bank_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_bank = '0;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_rb = '0;
  logic [11:0] cfg_start = '0, cfg_end = '0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        phase = 1'b0;
  logic [7:0]  cs_n;
  logic        ba;
  logic [11:0] ma;
  logic        no_bank;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sdram_bank_mux u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_bank_i(cfg_bank),
    .cfg_en_i(cfg_en), .cfg_row_bits_i(cfg_rb), .cfg_start_i(cfg_start),
    .cfg_end_i(cfg_end), .req_i(req), .addr_i(addr), .phase_i(phase),
    .cs_n_o(cs_n), .ba_o(ba), .ma_o(ma), .no_bank_o(no_bank)
  );

  function automatic logic be(logic [31:0] a, int n);
    return a[31-n];
  endfunction

  function automatic logic [12:0] exp_row(logic [31:0] a);
    logic [11:0] m = '0;
    for (int k = 1; k <= 11; k++) m[11-k] = be(a, 9 + k);
    return {be(a, 9), m};
  endfunction

  function automatic logic [12:0] exp_col(logic [31:0] a);
    logic [11:0] m = '0;
    for (int k = 1; k <= 3; k++)  m[11-k] = be(a, 5 + k);
    for (int k = 4; k <= 11; k++) m[11-k] = be(a, 17 + k);
    return {be(a, 5), m};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr_bank(int b, logic en, logic [1:0] rb, logic [11:0] s, logic [11:0] e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 3'(b); cfg_en = en; cfg_rb = rb; cfg_start = s; cfg_end = e;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // row phase on request, then column phase; expect select or miss
  task automatic access(string r, logic [31:0] a, logic [7:0] exp_cs);
    logic miss = (exp_cs == 8'hFF);
    @(negedge clk);
    req = 1'b1; addr = a; phase = 1'b0;
    @(negedge clk);
    chk({r, " cs"}, 32'(cs_n), 32'(exp_cs));
    chk({r, " miss R5"}, 32'(no_bank), 32'(miss));
    chk("R8 row map", 32'({ba, ma}), 32'(exp_row(a)));
    req = 1'b0; addr = ~a; phase = 1'b1;
    @(negedge clk);
    chk("R7 cs held", 32'(cs_n), 32'(exp_cs));
    chk("R5 miss one cycle", 32'(no_bank), 32'h0);
    chk("R9 col map", 32'({ba, ma}), 32'(exp_col(a)));
  endtask

  task automatic t_reset;
    chk("R1 cs", 32'(cs_n), 32'hFF);
    chk("R1 miss", 32'(no_bank), 32'h0);
    chk("R1 addr", 32'({ba, ma}), 32'h0);
  endtask

  task automatic t_config;
    wr_bank(0, 1, 2'b11, 12'h000, 12'h007);
    wr_bank(1, 1, 2'b11, 12'h008, 12'h017);
    wr_bank(2, 1, 2'b11, 12'h018, 12'h037);
    wr_bank(4, 1, 2'b10, 12'h040, 12'h047);
    wr_bank(5, 1, 2'b11, 12'h010, 12'h01F);
    wr_bank(7, 1, 2'b11, 12'h0F0, 12'h0FF);
  endtask

  task automatic t_ranges;
    access("R2 R3 bank0 base", 32'h0000_0000, 8'hFE);
    access("R3 bank0 last mb", 32'h007F_FFF8, 8'hFE);
    access("R3 bank1 first mb", 32'h0080_0000, 8'hFD);
    access("R3 bank2 last mb", 32'h037A_5A58, 8'hFB);
    access("R3 bank7 top", 32'h0FFF_FFFF, 8'h7F);
  endtask

  task automatic t_priority;
    access("R6 bank1 over bank5", 32'h0155_5550, 8'hFD);
    access("R6 bank2 over bank5", 32'h01AA_AAA8, 8'hFB);
  endtask

  task automatic t_miss;
    access("R5 gap", 32'h0380_0000, 8'hFF);
    access("R4 row code", 32'h0412_3458, 8'hFF);
  endtask

  task automatic t_disable;
    wr_bank(0, 0, 2'b11, 12'h000, 12'h007);
    access("R10 bank0 off", 32'h0000_1000, 8'hFF);
    wr_bank(1, 0, 2'b11, 12'h008, 12'h017);
    access("R10 bank5 now wins", 32'h0100_0000, 8'hDF);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_config();
    t_ranges();
    t_priority();
    t_miss();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule